// File: doc/BRIEF.md
# Three-Rail Power-Up and Power-Down Sequencer

This block turns a single push-button style on/off request into an ordered bring-up and tear-down of three supply rails. It drives one enable per rail and reads back one power-good flag per rail. Each flag comes from an external threshold comparator that reports the rail as good once it reaches 80% of its final value. A 1 ms tick from elsewhere on the chip clocks every delay, so the timing does not depend on the core clock frequency.

Bring-up is deliberately asymmetric with tear-down. On the way up, rail 1 starts first. Rail 2 follows only after rail 1 has stayed good for a settling window of 200 ticks. Rail 3 follows rail 2 as soon as rail 2 reports good. On the way down, rail 1 is removed first. Each later rail is then removed as soon as the rail before it drops below its threshold, with no timer involved. A request that arrives part way through bring-up turns the sequence around at once, starting from whatever rails are enabled at that moment.

The request input is a plain level and has no handshake. It counts as one event only after it has been held low for 32 consecutive ticks. It must then return high before it can count again. The block reports its sequence state and a done flag for the fully-on condition.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all three rail enables are low, `seq_state` is 0 (off) and `seq_done` is low.
- R2: A request event fires when `pwr_req_n` has been sampled low on 32 consecutive ticks. When the event fires from the off state, `rail_en[0]` (rail 1) rises within two clock cycles of the 32nd tick and `seq_state` becomes 1. A low period of fewer than 32 ticks, followed by release, enables nothing.
- R3: `rail_en[1]` rises only after `rail_good[0]` has been high on 200 consecutive ticks. It is still low after 199 such ticks and high within two clock cycles after the 200th. `seq_state` is 2 while the block waits for rail 2 to become good.
- R4: If `rail_good[0]` goes low during the 200-tick wait, the count is cleared. Rail 2 then waits for a fresh full 200 ticks of continuous good.
- R5: In state 2, `rail_en[2]` rises on the first clock edge at which `rail_good[1]` is high, with no tick delay. `seq_state` then becomes 3.
- R6: `seq_done` rises, and `seq_state` becomes 4, only after `rail_good[2]` is high while all three enables are set. `seq_done` is never high unless all three enables are high.
- R7: A request event in state 4 clears `rail_en[0]` only, leaves rails 2 and 3 enabled, and moves `seq_state` to 5 (power-down).
- R8: In state 5, `rail_en[1]` falls on the first clock edge at which `rail_good[0]` is low, and `rail_en[2]` falls on the first clock edge at which `rail_good[1]` is low. Once all enables are low, `seq_state` returns to 0.
- R9: A request event in state 1, 2 or 3 clears `rail_en[0]` at once, enters state 5, and tears down from whichever rails are currently enabled.
- R10: A request held low for any length of time produces one event only. Request events that arrive in state 5 leave the enables and the state unchanged.
- R11: Outside state 5 the enables stay nested: `rail_en[2]` implies `rail_en[1]`, and `rail_en[1]` implies `rail_en[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond; timebase for all delays |
| pwr_req_n | input | 1 | Active-low on/off request level from the push-button path |
| rail_good | input | 3 | Per-rail power-good flags, bit 0 is rail 1 |
| rail_en | output | 3 | Per-rail enables, bit 0 is rail 1 |
| seq_state | output | 3 | 0 off, 1 rail 1 up, 2 rail 2 up, 3 rail 3 up, 4 all on, 5 power-down |
| seq_done | output | 1 | High while all rails are up and good (state 4) |

## Verification
The bench places checks on both sides of each timed boundary. A debounce or settling counter that is off by one tick would enable a rail one tick early, or miss the window. A rail-1 glitch partway through the 200-tick wait is aimed at a timer that keeps its partial count, which would bring rail 2 up too early. The request line is held through the whole bring-up and later pulsed during tear-down. A design that re-arms without a release, or that listens to requests in power-down, would produce a spurious enable edge that the scoreboard rejects. An abort from state 2 is aimed at a design that always tears down from the fully-on pattern and would drop the wrong rails.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  localparam int RAILS = 3;

  typedef enum logic [2:0] {
    SQ_OFF   = 3'd0,
    SQ_RAIL1 = 3'd1,
    SQ_RAIL2 = 3'd2,
    SQ_RAIL3 = 3'd3,
    SQ_ON    = 3'd4,
    SQ_DOWN  = 3'd5
  } seq_state_e;

endpackage

// File: rtl/rseq_debounce.sv
module rseq_debounce #(
  parameter int HOLD_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req_n,
  output logic press
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          fired_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      press   <= 1'b0;
    end else begin
      press <= 1'b0;
      if (req_n) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (tick && !fired_q) begin
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          fired_q <= 1'b1;
          press   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R10
  single_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);
  // R2
  press_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press |-> $past(!req_n));

endmodule

// File: rtl/rseq_hold_timer.sv
module rseq_hold_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == TOP);

  // R4
  cleared_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> !expired);
  // R3
  expire_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(run));

endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
  import rseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             press,
  input  logic             delay_done,
  input  logic [RAILS-1:0] rail_good,
  output logic             delay_run,
  output logic [RAILS-1:0] rail_en,
  output seq_state_e       state,
  output logic             done
);
  seq_state_e       state_d;
  logic [RAILS-1:0] en_d;

  always_comb begin
    state_d = state;
    en_d    = rail_en;
    unique case (state)
      SQ_OFF: begin
        if (press) begin
          state_d = SQ_RAIL1;
          en_d    = 3'b001;
        end
      end
      SQ_RAIL1, SQ_RAIL2, SQ_RAIL3, SQ_ON: begin
        if (press) begin
          state_d    = SQ_DOWN;
          en_d[0]    = 1'b0;
        end else if (state == SQ_RAIL1 && delay_done) begin
          state_d = SQ_RAIL2;
          en_d    = 3'b011;
        end else if (state == SQ_RAIL2 && rail_good[1]) begin
          state_d = SQ_RAIL3;
          en_d    = 3'b111;
        end else if (state == SQ_RAIL3 && rail_good[2]) begin
          state_d = SQ_ON;
        end
      end
      SQ_DOWN: begin
        en_d[0] = 1'b0;
        if (!rail_good[0]) en_d[1] = 1'b0;
        if (!rail_good[1]) en_d[2] = 1'b0;
        if (rail_en == '0) state_d = SQ_OFF;
      end
      default: begin
        state_d = SQ_OFF;
        en_d    = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_OFF;
      rail_en <= '0;
    end else begin
      state   <= state_d;
      rail_en <= en_d;
    end
  end

  assign delay_run = (state == SQ_RAIL1) && rail_good[0];
  assign done      = (state == SQ_ON);

  // R3
  rail2_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[1]) |-> $past(delay_done));
  // R5
  rail3_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[2]) |-> $past(rail_good[1]));
  // R8
  rail2_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_en[1]) |-> $past(!rail_good[0]));
  // R8
  rail3_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_en[2]) |-> $past(!rail_good[1]));
  // R6
  done_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rail_en == 3'b111));
  // R11
  nested_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SQ_DOWN) |-> ((!rail_en[2] || rail_en[1]) && (!rail_en[1] || rail_en[0])));

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 32,
  parameter int SETTLE_TICKS   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic       pwr_req_n,
  input  logic [2:0] rail_good,
  output logic [2:0] rail_en,
  output logic [2:0] seq_state,
  output logic       seq_done
);
  logic       press;
  logic       delay_run;
  logic       delay_done;
  seq_state_e st;

  rseq_debounce #(.HOLD_TICKS(DEBOUNCE_TICKS)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_1ms),
    .req_n (pwr_req_n),
    .press (press)
  );

  rseq_hold_timer #(.LIMIT(SETTLE_TICKS)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1ms),
    .run     (delay_run),
    .expired (delay_done)
  );

  rseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .press      (press),
    .delay_done (delay_done),
    .rail_good  (rail_good),
    .delay_run  (delay_run),
    .rail_en    (rail_en),
    .state      (st),
    .done       (seq_done)
  );

  assign seq_state = st;

endmodule

// File: tb/rail_sequencer_tb_top.sv
module rail_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1ms = 1'b0;
  logic       pwr_req_n = 1'b1;
  logic [2:0] rail_good = 3'b000;
  logic [2:0] rail_en;
  logic [2:0] seq_state;
  logic       seq_done;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  logic [2:0] en_seen = 3'b000;
  logic [3:0] div = 4'd0;
  bit finished = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    div      <= div + 4'd1;
    tick_1ms <= (div == 4'd15);
  end

  rail_sequencer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1ms  (tick_1ms),
    .pwr_req_n (pwr_req_n),
    .rail_good (rail_good),
    .rail_en   (rail_en),
    .seq_state (seq_state),
    .seq_done  (seq_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor: every change on the enables must match the next expected pattern
  always @(negedge clk) begin
    if (rst_n && rail_en !== en_seen) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected enable edge", int'(rail_en), int'(en_seen));
      end else begin
        chk("R11 enable order", int'(rail_en), int'(exp_q.pop_front()));
      end
      en_seen = rail_en;
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (tick_1ms) k++;
    end
  endtask

  task automatic expect_en(input logic [2:0] v);
    exp_q.push_back(v);
  endtask

  initial begin
    clocks(4);
    chk("R1 enables in reset", int'(rail_en), 0);
    rst_n = 1'b1;
    clocks(1);
    chk("R1 enables after reset", int'(rail_en), 0);
    chk("R1 state after reset", int'(seq_state), 0);
    chk("R1 done after reset", int'(seq_done), 0);

    // R2: too-short press does nothing
    pwr_req_n = 1'b0;
    wait_ticks(20);
    pwr_req_n = 1'b1;
    clocks(40);
    chk("R2 short press ignored", int'(rail_en), 0);

    // R2: held press, boundary at 32 ticks (request kept low for R10)
    pwr_req_n = 1'b0;
    wait_ticks(31);
    clocks(4);
    chk("R2 no enable at 31 ticks", int'(rail_en), 0);
    expect_en(3'b001);
    wait_ticks(1);
    clocks(4);
    chk("R2 rail 1 on at 32 ticks", int'(rail_en), 1);
    chk("R2 state rail1", int'(seq_state), 1);

    // R4: glitch on rail 1 good restarts the wait
    rail_good[0] = 1'b1;
    wait_ticks(150);
    rail_good[0] = 1'b0;
    clocks(2);
    rail_good[0] = 1'b1;
    wait_ticks(199);
    clocks(4);
    chk("R4 rail 2 still off after restart", int'(rail_en), 1);
    expect_en(3'b011);
    wait_ticks(1);
    clocks(4);
    chk("R3 rail 2 on after 200 ticks", int'(rail_en), 3);
    chk("R3 state rail2", int'(seq_state), 2);

    // R5: rail 3 follows at once
    clocks(30);
    chk("R5 rail 3 waits for good", int'(rail_en), 3);
    expect_en(3'b111);
    rail_good[1] = 1'b1;
    clocks(2);
    chk("R5 rail 3 on immediately", int'(rail_en), 7);
    chk("R5 state rail3", int'(seq_state), 3);
    chk("R6 done low before rail 3 good", int'(seq_done), 0);
    rail_good[2] = 1'b1;
    clocks(2);
    chk("R6 done high", int'(seq_done), 1);
    chk("R6 state on", int'(seq_state), 4);

    // R10: request held all along produced one event only
    wait_ticks(40);
    chk("R10 held request no second event", int'(rail_en), 7);
    pwr_req_n = 1'b1;
    clocks(4);

    // R7: power-down removes rail 1 first
    expect_en(3'b110);
    pwr_req_n = 1'b0;
    wait_ticks(32);
    clocks(4);
    chk("R7 rail 1 removed first", int'(rail_en), 6);
    chk("R7 state down", int'(seq_state), 5);
    chk("R7 done cleared", int'(seq_done), 0);
    pwr_req_n = 1'b1;
    clocks(4);

    // R10: request during power-down ignored
    pwr_req_n = 1'b0;
    wait_ticks(40);
    pwr_req_n = 1'b1;
    clocks(4);
    chk("R10 request in power-down ignored", int'(rail_en), 6);
    chk("R10 state unchanged", int'(seq_state), 5);

    // R8: cascade follows good flags with no delay
    expect_en(3'b100);
    rail_good[0] = 1'b0;
    clocks(2);
    chk("R8 rail 2 off after rail 1 bad", int'(rail_en), 4);
    expect_en(3'b000);
    rail_good[1] = 1'b0;
    clocks(2);
    chk("R8 rail 3 off after rail 2 bad", int'(rail_en), 0);
    rail_good[2] = 1'b0;
    clocks(3);
    chk("R8 back to off", int'(seq_state), 0);

    // R9: abort from state 2
    expect_en(3'b001);
    pwr_req_n = 1'b0;
    wait_ticks(32);
    clocks(4);
    pwr_req_n = 1'b1;
    chk("R9 rail 1 on again", int'(rail_en), 1);
    rail_good[0] = 1'b1;
    expect_en(3'b011);
    wait_ticks(201);
    clocks(4);
    chk("R9 rail 2 on", int'(rail_en), 3);
    expect_en(3'b010);
    pwr_req_n = 1'b0;
    wait_ticks(32);
    clocks(4);
    pwr_req_n = 1'b1;
    chk("R9 abort clears rail 1 only", int'(rail_en), 2);
    chk("R9 state down", int'(seq_state), 5);
    expect_en(3'b000);
    rail_good[0] = 1'b0;
    clocks(3);
    chk("R9 rail 2 removed", int'(rail_en), 0);
    chk("R9 state off", int'(seq_state), 0);

    clocks(10);
    chk("R11 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule